// File: doc/BRIEF.md
# Redundant-Execution Mode Controller

This block decides when a processor core leaves its normal performance mode to re-execute and check already retired work, and when it goes back. Checking is meant to run in otherwise idle time: a long-latency second-level cache miss that has been waiting a set number of cycles starts a checking episode, and the episode ends when that miss is serviced or when the record of work to be checked has drained. A full record buffer, a system call or an I/O interaction forces a checking episode regardless of memory stalls; a forced episode ends only when the buffer is empty.

Each change of mode is a fixed sequence: the controller asks the pipeline to flush, waits for the flush to finish, flips its mode bit and then pulses a fetch redirect for one cycle. The redirect names the register file whose PC fetch restarts from: the checking register file when entering checking mode, the performance register file when leaving it. Trigger events that arrive while a sequence is in flight are dropped. The pipeline, caches and register files lie outside the block and drive its inputs.

Top module: `redexec_mode_ctrl`

## Requirements
- R1: After synchronous reset the block is in performance mode (`check_mode`=0) with `flush_req`=0 and `redirect_vld`=0.
- R2: In performance mode with no switch in flight, `miss_pending` held high for `WAIT_CYC` (default 30) consecutive clock edges raises `flush_req` at the next edge; a pending miss dropped earlier raises nothing and its count restarts from zero.
- R3: In performance mode with no switch in flight, a one-cycle `blog_full` or `sys_evt` raises `flush_req` at the next edge.
- R4: `flush_req` stays high until `flush_done` is sampled high; at that edge `check_mode` toggles and `flush_req` falls.
- R5: `redirect_vld` is high for exactly the one cycle in which the new mode first shows; `redirect_src` is 1 (checking register file) on entry and 0 (performance register file) on exit.
- R6: In checking mode with no switch in flight, `blog_empty` high, or a `miss_done` pulse when the episode was started by a miss wait, raises `flush_req` at the next edge.
- R7: When an episode was started by `blog_full` or `sys_evt`, `miss_done` does not end it; only `blog_empty` does.
- R8: Trigger inputs sampled while a switch sequence is in flight are ignored and not remembered afterwards.
- R9: The miss-wait count does not advance in checking mode; after a return to performance mode a still-pending miss needs a full fresh `WAIT_CYC` cycles before it triggers entry.
- R10: If a miss-wait expiry and a forced trigger are sampled together, the episode is treated as forced (R7 applies).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_pending | input | 1 | A long-latency cache miss is outstanding |
| miss_done | input | 1 | One-cycle pulse: the outstanding miss has been serviced |
| blog_full | input | 1 | The buffer of work awaiting checking is full |
| blog_empty | input | 1 | The buffer of work awaiting checking is empty |
| sys_evt | input | 1 | A system call or I/O interaction is being retired |
| flush_done | input | 1 | The pipeline has finished the requested flush |
| check_mode | output | 1 | Current mode: 0 performance, 1 checking |
| flush_req | output | 1 | Request to flush the pipeline |
| redirect_vld | output | 1 | One-cycle fetch redirect request |
| redirect_src | output | 1 | Register file supplying the restart PC: 0 performance, 1 checking |

## Verification
The hardest situation to reach is a miss that stays pending across a whole checking episode that then ends on buffer drain rather than on the miss, because it needs the stall count, the mode exit and the count restart to line up. The stimulus holds `miss_pending` high through entry, checking and a `blog_empty` exit, then counts edges from the redirect cycle to show that a fresh full wait is needed. Forced-versus-stall precedence is reached by raising `blog_full` in exactly the cycle the miss wait expires.

// File: rtl/redexec_pkg.sv
package redexec_pkg;

    typedef enum logic {
        MODE_PERF  = 1'b0,
        MODE_CHECK = 1'b1
    } core_mode_e;

    typedef enum logic {
        RF_PERF  = 1'b0,
        RF_CHECK = 1'b1
    } rf_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FLUSH = 2'd1,
        SQ_REDIR = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic go;
        logic forced;
    } switch_req_t;

    typedef struct packed {
        logic miss_done;
        logic blog_full;
        logic blog_empty;
        logic sys_evt;
    } trig_in_t;

    function automatic logic forced_source(input trig_in_t t);
        return t.blog_full | t.sys_evt;
    endfunction

    function automatic rf_sel_e rf_for_mode(input core_mode_e m);
        return (m == MODE_CHECK) ? RF_CHECK : RF_PERF;
    endfunction

endpackage

// File: rtl/redexec_stall_timer.sv
module redexec_stall_timer #(
    parameter int WAIT_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic miss_pending,
    input  logic miss_done,
    input  logic check_mode,
    output logic stall_expired
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

    logic [CW-1:0] cnt_q;
    logic          clear;

    assign clear = !miss_pending || miss_done || check_mode;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stall_expired = (cnt_q == LIMIT);

    // R9: no count can build up across a checking episode
    p_no_count_in_check_r9: assert property (@(posedge clk) disable iff (rst)
        check_mode |=> !stall_expired);

    // R2: once expired, a miss that stays pending in performance mode keeps it expired
    p_expiry_sticks_r2: assert property (@(posedge clk) disable iff (rst)
        (stall_expired && miss_pending && !miss_done && !check_mode) |=> stall_expired);

endmodule

// File: rtl/redexec_trigger_arb.sv
module redexec_trigger_arb
    import redexec_pkg::*;
(
    input  core_mode_e        mode,
    input  logic              seq_idle,
    input  logic              forced_ep,
    input  logic              stall_expired,
    input  trig_in_t          trig,
    output switch_req_t       req
);
    logic enter_cond;
    logic leave_cond;

    always_comb begin
        enter_cond = stall_expired || forced_source(trig);
        leave_cond = trig.blog_empty || (trig.miss_done && !forced_ep);
        req.forced = forced_source(trig);
        req.go     = 1'b0;
        if (seq_idle) begin
            if (mode == MODE_PERF) begin
                req.go = enter_cond;
            end else begin
                req.go = leave_cond;
            end
        end
    end

    // R8: nothing is requested while a sequence is in flight
    always_comb begin
        if (!seq_idle) begin
            p_no_req_busy_r8: assert (!req.go);
        end
    end

endmodule

// File: rtl/redexec_switch_seq.sv
module redexec_switch_seq
    import redexec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  switch_req_t req,
    input  logic        flush_done,
    output core_mode_e  mode,
    output logic        seq_idle,
    output logic        forced_ep,
    output logic        flush_req,
    output logic        redirect_vld,
    output rf_sel_e     redirect_src
);
    seq_state_e state_q;
    core_mode_e mode_q;
    logic       forced_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            mode_q   <= MODE_PERF;
            forced_q <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (req.go) begin
                        state_q <= SQ_FLUSH;
                        if (mode_q == MODE_PERF) begin
                            forced_q <= req.forced;
                        end
                    end
                end
                SQ_FLUSH: begin
                    if (flush_done) begin
                        state_q <= SQ_REDIR;
                        if (mode_q == MODE_PERF) begin
                            mode_q <= MODE_CHECK;
                        end else begin
                            mode_q   <= MODE_PERF;
                            forced_q <= 1'b0;
                        end
                    end
                end
                SQ_REDIR: begin
                    state_q <= SQ_IDLE;
                end
                default: begin
                    state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    assign mode         = mode_q;
    assign seq_idle     = (state_q == SQ_IDLE);
    assign forced_ep    = forced_q;
    assign flush_req    = (state_q == SQ_FLUSH);
    assign redirect_vld = (state_q == SQ_REDIR);
    assign redirect_src = rf_for_mode(mode_q);

    // R4: the flush request is held until the pipeline answers
    p_flush_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !flush_done) |=> flush_req);

    // R4: the mode only changes right after a completed flush
    p_mode_after_flush_r4: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |-> $past(flush_req && flush_done));

    // R5: redirect lasts one cycle
    p_redirect_single_r5: assert property (@(posedge clk) disable iff (rst)
        redirect_vld |=> !redirect_vld);

    // R5: a redirect follows a flush handshake
    p_redirect_after_flush_r5: assert property (@(posedge clk) disable iff (rst)
        redirect_vld |-> $past(flush_done));

    // R7: a forced episode is left only on buffer drain
    p_forced_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && mode == MODE_CHECK && forced_ep && !req.go) |=> !flush_req);

endmodule

// File: rtl/redexec_mode_ctrl.sv
module redexec_mode_ctrl
    import redexec_pkg::*;
#(
    parameter int WAIT_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic miss_pending,
    input  logic miss_done,
    input  logic blog_full,
    input  logic blog_empty,
    input  logic sys_evt,
    input  logic flush_done,
    output logic check_mode,
    output logic flush_req,
    output logic redirect_vld,
    output logic redirect_src
);
    core_mode_e  mode;
    logic        seq_idle;
    logic        forced_ep;
    logic        stall_expired;
    trig_in_t    trig;
    switch_req_t req;
    rf_sel_e     rf_sel;

    assign trig = '{miss_done: miss_done, blog_full: blog_full,
                    blog_empty: blog_empty, sys_evt: sys_evt};

    redexec_stall_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk           (clk),
        .rst           (rst),
        .miss_pending  (miss_pending),
        .miss_done     (miss_done),
        .check_mode    (mode == MODE_CHECK),
        .stall_expired (stall_expired)
    );

    redexec_trigger_arb u_arb (
        .mode          (mode),
        .seq_idle      (seq_idle),
        .forced_ep     (forced_ep),
        .stall_expired (stall_expired),
        .trig          (trig),
        .req           (req)
    );

    redexec_switch_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .req           (req),
        .flush_done    (flush_done),
        .mode          (mode),
        .seq_idle      (seq_idle),
        .forced_ep     (forced_ep),
        .flush_req     (flush_req),
        .redirect_vld  (redirect_vld),
        .redirect_src  (rf_sel)
    );

    assign check_mode   = (mode == MODE_CHECK);
    assign redirect_src = (rf_sel == RF_CHECK);

    // R1: reset leaves the block quiet in performance mode
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!check_mode && !flush_req && !redirect_vld));

endmodule

// File: tb/redexec_mode_ctrl_bench.sv
module redexec_mode_ctrl_bench;

    localparam int WAIT = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_pending = 1'b0, miss_done = 1'b0, blog_full = 1'b0;
    logic blog_empty = 1'b1, sys_evt = 1'b0, flush_done = 1'b0;
    logic check_mode, flush_req, redirect_vld, redirect_src;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    redexec_mode_ctrl #(.WAIT_CYC(WAIT)) u_redexec_mode_ctrl (
        .clk(clk), .rst(rst), .miss_pending(miss_pending), .miss_done(miss_done),
        .blog_full(blog_full), .blog_empty(blog_empty), .sys_evt(sys_evt),
        .flush_done(flush_done), .check_mode(check_mode), .flush_req(flush_req),
        .redirect_vld(redirect_vld), .redirect_src(redirect_src)
    );

    // {blog_full, sys_evt, expect_entry}
    localparam logic [2:0] VEC [4] = '{3'b000, 3'b101, 3'b011, 3'b111};

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic act, input logic exp);
        chk(act === exp, req, int'(act), int'(exp));
    endtask

    // flush_req is high on entry; completes the handshake and checks the new mode
    task automatic handshake(input logic to_check);
        flush_done = 1'b1;
        tick();
        flush_done = 1'b0;
        chk_eq("R4 mode toggled", check_mode, to_check);
        chk_eq("R4 flush dropped", flush_req, 1'b0);
        chk_eq("R5 redirect valid", redirect_vld, 1'b1);
        chk_eq("R5 redirect source", redirect_src, to_check);
        tick();
        chk_eq("R5 redirect one cycle", redirect_vld, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        chk_eq("R1 mode", check_mode, 1'b0);
        chk_eq("R1 flush", flush_req, 1'b0);
        chk_eq("R1 redirect", redirect_vld, 1'b0);
        blog_empty = 1'b0;

        // R2: short miss does nothing
        miss_pending = 1'b1;
        repeat (WAIT - 1) tick();
        miss_pending = 1'b0;
        tick();
        chk_eq("R2 short miss", flush_req, 1'b0);

        // R2: full wait triggers entry
        miss_pending = 1'b1;
        repeat (WAIT) tick();
        chk_eq("R2 not before wait", flush_req, 1'b0);
        tick();
        chk_eq("R2 entry after wait", flush_req, 1'b1);
        repeat (3) tick();
        chk_eq("R4 flush held", flush_req, 1'b1);
        chk_eq("R4 mode held", check_mode, 1'b0);
        handshake(1'b1);
        repeat (40) tick();
        chk_eq("R9 no stall trigger in check", flush_req, 1'b0);
        miss_done = 1'b1; miss_pending = 1'b0;
        tick();
        miss_done = 1'b0;
        chk_eq("R6 miss serviced exit", flush_req, 1'b1);
        handshake(1'b0);

        // R3 / R7 / R6 table
        foreach (VEC[i]) begin
            blog_full = VEC[i][2];
            sys_evt   = VEC[i][1];
            tick();
            blog_full = 1'b0; sys_evt = 1'b0;
            chk_eq("R3 forced entry", flush_req, VEC[i][0]);
            if (VEC[i][0]) begin
                handshake(1'b1);
                miss_done = 1'b1;
                tick();
                miss_done = 1'b0;
                tick();
                chk_eq("R7 miss_done ignored", flush_req, 1'b0);
                blog_empty = 1'b1;
                tick();
                blog_empty = 1'b0;
                chk_eq("R6 empty exit", flush_req, 1'b1);
                handshake(1'b0);
            end
        end

        // R10: stall expiry and full together
        miss_pending = 1'b1;
        repeat (WAIT) tick();
        blog_full = 1'b1;
        tick();
        blog_full = 1'b0;
        chk_eq("R10 entry", flush_req, 1'b1);
        handshake(1'b1);
        miss_done = 1'b1; miss_pending = 1'b0;
        tick();
        miss_done = 1'b0;
        tick();
        chk_eq("R10 treated as forced", flush_req, 1'b0);
        blog_empty = 1'b1;
        tick();
        blog_empty = 1'b0;
        handshake(1'b0);

        // R8: trigger during exit sequence is dropped
        sys_evt = 1'b1;
        tick();
        sys_evt = 1'b0;
        handshake(1'b1);
        blog_empty = 1'b1;
        tick();
        blog_empty = 1'b0;
        sys_evt = 1'b1;
        tick();
        sys_evt = 1'b0;
        chk_eq("R8 flush still pending", flush_req, 1'b1);
        chk_eq("R8 mode unchanged", check_mode, 1'b1);
        handshake(1'b0);
        repeat (3) tick();
        chk_eq("R8 pulse not remembered", flush_req, 1'b0);

        // R9: count restarts after exit with miss still pending
        miss_pending = 1'b1;
        repeat (WAIT + 1) tick();
        chk_eq("R9 stall entry", flush_req, 1'b1);
        handshake(1'b1);
        blog_empty = 1'b1;
        tick();
        blog_empty = 1'b0;
        chk_eq("R9 drain exit", flush_req, 1'b1);
        handshake(1'b0);
        repeat (WAIT - 1) tick();
        chk_eq("R9 fresh wait not done", flush_req, 1'b0);
        tick();
        chk_eq("R9 fresh wait done", flush_req, 1'b1);
        handshake(1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule